// File: doc/BRIEF.md
# Overloaded Digit Merge and BCD Cleanup Pipe

This block takes two 4-bit digits of equal decimal weight each cycle. Either digit may be in the overloaded range, where the codes A to F still stand for ten to fifteen. The block adds the two digits and the carry left by the previous digit. It returns one valid BCD digit and a decimal carry of zero to three. The carry is kept inside the block and added to the next valid digit of the same number, one decimal place higher, so a stream of digit pairs fed least significant first leaves the block as a clean BCD number.

The work is spread over four register stages:
- Stage one folds the first digit back into the 0 to 9 range by adding zero or six.
- Stage two uses a bitwise carry-save adder to combine the folded digit, the second digit and a zero-or-six factor for the second digit.
- Stage three resolves the carry-save pair, adds the carry held from the previous digit and works out the new carry.
- Stage four adds zero, six or twelve to bring the low nibble back into BCD.

Valid travels with the data. A new digit pair may enter on every cycle. A start flag marks the first digit of a new number and forces its incoming carry to zero.

Top module: `ovl_bcd_cleanup`

## Requirements
- R1: Whenever `out_vld` is high, `out_bcd` lies in 0 to 9.
- R2: A pair accepted in cycle n (with `in_vld` high) appears on the outputs in cycle n+4, and `out_vld` equals `in_vld` from four cycles earlier.
- R3: For every valid output, `out_bcd + 10*out_cy` equals `in_dig_a + in_dig_b + cin`, where each digit counts at its binary value 0 to 15 and cin is the `out_cy` of the previous valid digit.
- R4: An input digit with code A to F counts as ten to fifteen. For example, A plus 0 with no incoming carry gives digit 0 and carry 1.
- R5: `out_cy` holds the full decimal carry, which can reach 3 (F plus F plus an incoming 3 gives digit 3, carry 3).
- R6: Pairs presented on consecutive cycles each produce a result on consecutive cycles, with no bubble needed.
- R7: Cycles with `in_vld` low do not alter the carry that is waiting. The next valid digit receives the carry of the last valid one.
- R8: When `in_first` is high with a valid pair, the incoming carry for that pair is zero.
- R9: Synchronous active-high `rst` clears `out_vld`, `out_bcd` and `out_cy` to zero.
- R10: While `in_vld` is low, `in_dig_a`, `in_dig_b` and `in_first` have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Digit pair present this cycle |
| in_first | input | 1 | Pair is the least significant digit of a new number |
| in_dig_a | input | 4 | First overloaded digit, 0 to 15 |
| in_dig_b | input | 4 | Second overloaded digit, 0 to 15 |
| out_vld | output | 1 | Result digit present |
| out_bcd | output | 4 | BCD result digit |
| out_cy | output | 2 | Decimal carry of the result digit, 0 to 3 |

## Verification
The assertions assume that the incoming carry never exceeds three. They also assume that, in stage three, a second digit above nine always leaves bit four of the resolved carry-save sum set. Both follow when every input digit is a 4-bit value and the carry chain starts from zero, either after reset or with a start flag. The stimulus therefore opens each number with `in_first`, drives plain 4-bit digits, and sends garbage codes (F, F, start) only in cycles where `in_vld` is low. A reference carry chain kept in the bench predicts every digit and carry.

// File: rtl/ovl_cln_pkg.sv
package ovl_cln_pkg;
  localparam int DIG_W = 4;
  localparam int CY_W  = 2;
  localparam int SUM_W = DIG_W + 1;

  typedef struct packed {
    logic             vld;
    logic             first;
    logic             u_c;
    logic [DIG_W-1:0] u_dig;
    logic [DIG_W-1:0] b;
  } s1_t;

  typedef struct packed {
    logic             vld;
    logic             first;
    logic             u_c;
    logic             h;
    logic [SUM_W-1:0] ps;
    logic [SUM_W-1:0] pc;
  } s2_t;

  typedef struct packed {
    logic             vld;
    logic [SUM_W-1:0] y;
    logic [1:0]       k;
    logic [CY_W-1:0]  cy;
  } s3_t;

  function automatic logic is_ovl(input logic [DIG_W-1:0] d);
    return d > 4'd9;
  endfunction
endpackage

// File: rtl/ovl_s1_fix.sv
module ovl_s1_fix
  import ovl_cln_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_first,
  input  logic [DIG_W-1:0] a,
  input  logic [DIG_W-1:0] b,
  output s1_t              q
);
  logic             hi;
  logic [DIG_W-1:0] fixed;

  always_comb begin
    hi    = is_ovl(a);
    fixed = a + (hi ? 4'd6 : 4'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.vld   <= in_vld;
      q.first <= in_first;
      q.u_c   <= hi;
      q.u_dig <= fixed;
      q.b     <= b;
    end
  end

  // R4: folded first digit is always a decimal digit
  p_s1_digit_r4: assert property (@(posedge clk) disable iff (rst)
    q.vld |-> q.u_dig <= 4'd9);
endmodule

// File: rtl/ovl_s2_csa.sv
module ovl_s2_csa
  import ovl_cln_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  s1_t  d,
  output s2_t  q
);
  logic             h;
  logic [SUM_W-1:0] op0, op1, op2;
  logic [SUM_W-1:0] sv, cv;

  always_comb begin
    h   = is_ovl(d.b);
    op0 = {1'b0, d.u_dig};
    op1 = {1'b0, d.b};
    op2 = h ? SUM_W'(6) : '0;
  end

  for (genvar i = 0; i < SUM_W; i++) begin : g_csa
    assign sv[i] = op0[i] ^ op1[i] ^ op2[i];
    assign cv[i] = (op0[i] & op1[i]) | (op0[i] & op2[i]) | (op1[i] & op2[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.vld   <= d.vld;
      q.first <= d.first;
      q.u_c   <= d.u_c;
      q.h     <= h;
      q.ps    <= sv;
      q.pc    <= {cv[SUM_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ovl_s3_merge.sv
module ovl_s3_merge
  import ovl_cln_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  s2_t  d,
  output s3_t  q
);
  logic [SUM_W-1:0] t;
  logic [CY_W-1:0]  cin;
  logic [SUM_W-1:0] y;
  logic [1:0]       k;
  logic [2:0]       cy_wide;

  always_comb begin
    t       = d.ps + d.pc;
    cin     = d.first ? '0 : q.cy;
    y       = {t[4] & ~d.h, t[3:0]} + {3'b000, cin};
    k       = (y >= 5'd20) ? 2'd2 : ((y >= 5'd10) ? 2'd1 : 2'd0);
    cy_wide = {2'b00, d.u_c} + {2'b00, d.h} + {1'b0, k};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.vld <= d.vld;
      if (d.vld) begin
        q.y  <= y;
        q.k  <= k;
        q.cy <= cy_wide[CY_W-1:0];
      end
    end
  end

  // R3: a corrected second digit always lands on the 16 weight
  p_csa_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (d.vld && d.h) |-> t[4]);
  // R5: carry never exceeds two bits
  p_cy_fit_r5: assert property (@(posedge clk) disable iff (rst)
    d.vld |-> cy_wide <= 3'd3);
endmodule

// File: rtl/ovl_s4_bcd.sv
module ovl_s4_bcd
  import ovl_cln_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  s3_t              d,
  output logic             o_vld,
  output logic [DIG_W-1:0] o_bcd,
  output logic [CY_W-1:0]  o_cy
);
  logic [DIG_W-1:0] corr;

  always_comb begin
    unique case (d.k)
      2'd1:    corr = 4'd6;
      2'd2:    corr = 4'd12;
      default: corr = 4'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_bcd <= '0;
      o_cy  <= '0;
    end else begin
      o_vld <= d.vld;
      o_bcd <= d.y[DIG_W-1:0] + corr;
      o_cy  <= d.cy;
    end
  end

  // R3: merged sum before correction stays within 21
  p_y_bound_r3: assert property (@(posedge clk) disable iff (rst)
    d.vld |-> d.y <= 5'd21);
  // R1: every valid output digit is BCD
  p_bcd_range_r1: assert property (@(posedge clk) disable iff (rst)
    o_vld |-> o_bcd <= 4'd9);
endmodule

// File: rtl/ovl_bcd_cleanup.sv
module ovl_bcd_cleanup
  import ovl_cln_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic       in_first,
  input  logic [3:0] in_dig_a,
  input  logic [3:0] in_dig_b,
  output logic       out_vld,
  output logic [3:0] out_bcd,
  output logic [1:0] out_cy
);
  localparam int LAT   = 4;
  localparam int RUN_W = $clog2(LAT + 2);

  s1_t s1_q;
  s2_t s2_q;
  s3_t s3_q;

  ovl_s1_fix u_s1 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_first(in_first),
    .a(in_dig_a), .b(in_dig_b), .q(s1_q)
  );

  ovl_s2_csa u_s2 (.clk(clk), .rst(rst), .d(s1_q), .q(s2_q));

  ovl_s3_merge u_s3 (.clk(clk), .rst(rst), .d(s2_q), .q(s3_q));

  ovl_s4_bcd u_s4 (
    .clk(clk), .rst(rst), .d(s3_q),
    .o_vld(out_vld), .o_bcd(out_bcd), .o_cy(out_cy)
  );

  logic [RUN_W-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (run_cnt != RUN_W'(LAT + 1)) run_cnt <= run_cnt + 1'b1;
  end

  // R2: valid emerges exactly four cycles after entry
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == RUN_W'(LAT + 1)) |-> (out_vld == $past(in_vld, 4)));
endmodule

// File: tb/sim_ovl_bcd_cleanup.sv
module sim_ovl_bcd_cleanup;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       in_first = 1'b0;
  logic [3:0] in_dig_a = '0;
  logic [3:0] in_dig_b = '0;
  logic       out_vld;
  logic [3:0] out_bcd;
  logic [1:0] out_cy;

  always #2 clk = ~clk;

  ovl_bcd_cleanup u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_first(in_first),
    .in_dig_a(in_dig_a), .in_dig_b(in_dig_b),
    .out_vld(out_vld), .out_bcd(out_bcd), .out_cy(out_cy)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {first, a, b, exp_digit, exp_carry}
  localparam int NV = 10;
  localparam logic [14:0] VEC [0:NV-1] = '{
    {1'b1, 4'hF, 4'hF, 4'd0, 2'd3},
    {1'b0, 4'h9, 4'h9, 4'd1, 2'd2},
    {1'b0, 4'hA, 4'h0, 4'd2, 2'd1},
    {1'b0, 4'h0, 4'h0, 4'd1, 2'd0},
    {1'b1, 4'h5, 4'h4, 4'd9, 2'd0},
    {1'b0, 4'hC, 4'hD, 4'd5, 2'd2},
    {1'b0, 4'h7, 4'h1, 4'd0, 2'd1},
    {1'b1, 4'h0, 4'h0, 4'd0, 2'd0},
    {1'b0, 4'hF, 4'hF, 4'd0, 2'd3},
    {1'b0, 4'hF, 4'hF, 4'd3, 2'd3}
  };

  localparam int NR = 60;
  logic       ev [0:NR-1];
  logic [3:0] ed [0:NR-1];
  logic [1:0] ec [0:NR-1];
  logic       gap_before [0:NR-1];

  initial begin
    logic [15:0] lfsr;
    int          c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 out_vld after reset", out_vld, 0);
    chk("R9 out_bcd after reset", out_bcd, 0);
    chk("R9 out_cy after reset", out_cy, 0);

    // table walk: R3 R4 R5 R6 R8 back-to-back
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk("R2/R6 out_vld table", out_vld, 1);
        chk("R3/R4/R5/R8 digit table", out_bcd, VEC[i-4][5:2]);
        chk("R3/R5 carry table", out_cy, VEC[i-4][1:0]);
        chk("R1 range table", out_bcd <= 4'd9, 1);
      end else begin
        chk("R2 out_vld before arrival", out_vld, 0);
      end
      if (i < NV) begin
        in_vld   = 1'b1;
        in_first = VEC[i][14];
        in_dig_a = VEC[i][13:10];
        in_dig_b = VEC[i][9:6];
      end else begin
        in_vld = 1'b0;
      end
    end

    // gapped stream with garbage in idle cycles: R7 R10
    lfsr = 16'hACE1;
    c    = 0;
    for (int i = 0; i < NR + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk("R2 out_vld gapped", out_vld, ev[i-4]);
        if (ev[i-4]) begin
          if (gap_before[i-4]) begin
            chk("R7/R10 digit after gap", out_bcd, ed[i-4]);
            chk("R7/R10 carry after gap", out_cy, ec[i-4]);
          end else begin
            chk("R3 digit gapped", out_bcd, ed[i-4]);
            chk("R3 carry gapped", out_cy, ec[i-4]);
          end
          chk("R1 range gapped", out_bcd <= 4'd9, 1);
        end
      end
      if (i < NR) begin
        if ((i % 3) != 1) begin
          int s;
          logic f;
          f = (i % 7) == 0;
          in_vld   = 1'b1;
          in_first = f;
          in_dig_a = lfsr[3:0];
          in_dig_b = lfsr[7:4];
          s = int'(lfsr[3:0]) + int'(lfsr[7:4]) + (f ? 0 : c);
          ev[i] = 1'b1;
          ed[i] = 4'(s % 10);
          ec[i] = 2'(s / 10);
          c = s / 10;
          gap_before[i] = (i > 0) && ((i - 1) % 3 == 1);
        end else begin
          in_vld   = 1'b0;
          in_first = 1'b1;
          in_dig_a = 4'hF;
          in_dig_b = 4'hF;
          ev[i] = 1'b0;
          ed[i] = '0;
          ec[i] = '0;
          gap_before[i] = 1'b0;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else begin
        in_vld = 1'b0;
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule